// File: doc/BRIEF.md
# Accelerator Invocation and Callback Controller

This block sits between a host processor and a hardware kernel. The host reaches it through a register read/write port. It loads one register for each kernel input (a parameter value or the address of a global variable) and then writes a start command. The block runs the kernel and captures its results into read-only output registers. It then raises a level interrupt and holds it until the host acknowledges it. The acknowledge returns the block to its initial idle state.

While it runs, the kernel can ask for a software service. The block freezes the kernel with all of its state kept. It publishes the service arguments in registers and reports the service number both in the status register and on a port that travels with the interrupt. The host runs the service, writes the service results into result registers and gives a resume command.

Around each call the block can run two cache handshakes, and a per-service configuration bit can skip either one:
- a flush request before the host is told about the call;
- an invalidate request before the kernel continues.

The kernel here is a stub. It runs a fixed number of steps, optionally requests one service, runs again and finishes.

Top module: `accel_ctl`

## Requirements
- R1: After reset the status register (address 0x01) reads state code 0 (idle) and `irq` is low. Argument registers at 0x10 upward read back what the host wrote.
- R2: Writing the control register (0x00) with bit 0 set starts the kernel only from idle, after which the status state code (bits 1:0) reads 1 (running). A start given in any other state is ignored.
- R3: When the kernel ends, the status code reads 3 (done) and `irq` rises. Without a service call, out register 0x20 holds arg1+arg2 and 0x21 holds arg3. With a call, 0x20 holds result0+arg1 and 0x21 holds result1. All sums are modulo 2^32.
- R4: A control write with bit 2 set (interrupt acknowledge) in the done state returns the block to idle (code 0) and clears `irq`.
- R5: When arg0 bit 4 is set, the kernel requests service number arg0[1:0]. The block then shows code 2 (service pending), raises `irq`, places the service number in status bits 11:8 and on `irq_svc_id`, and sets 0x30 to arg1+arg2 and 0x31 to arg3.
- R6: While a service is pending, the kernel makes no progress, however long the host waits.
- R7: Before entering the pending state, the block holds `flush_req` until `flush_ack` arrives. This step is skipped when bit N of the configuration register (0x02) is set for service N.
- R8: After resume, the block holds `inval_req` until `inval_ack` arrives and only then lets the kernel continue. This step is skipped when configuration bit 8+N is set for service N.
- R9: A resume command (control bit 1) given in any state other than service pending has no effect.
- R10: `irq` stays high until an acknowledge write, including in the pending state, where the acknowledge clears `irq` but leaves the state code at 2. Status bit 16 mirrors `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Level interrupt: done or service pending |
| irq_svc_id | output | 2 | Service number travelling with the interrupt |
| flush_req | output | 1 | Cache flush request |
| flush_ack | input | 1 | Cache flush acknowledge |
| inval_req | output | 1 | Cache invalidate request |
| inval_ack | input | 1 | Cache invalidate acknowledge |

## Verification
The hardest situation to reach is a kernel that stays frozen mid-call while the host does unrelated things. Examples are a second start, an early interrupt acknowledge, or a long idle wait, and each must leave the pending state and service arguments untouched. The stimulus gets there by starting a call-enabled vector, waiting for the interrupt, and only then issuing those writes. The other configuration combinations are walked by a vector table. It covers flush only, invalidate only, both handshakes and neither, so each handshake is seen both taken and skipped. A bench responder delays every acknowledge by several cycles, so that the request has to be held.

// File: rtl/accel_pkg.sv
package accel_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RUN, S_FLUSH, S_PEND, S_INVAL, S_DONE
    } seq_st_e;

    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_CFG  = 2;
    localparam int A_ARG  = 16;
    localparam int A_OUT  = 32;
    localparam int A_SARG = 48;
    localparam int A_SRES = 56;

    localparam int C_START  = 0;
    localparam int C_RESUME = 1;
    localparam int C_ACK    = 2;

    localparam int CB_BIT   = 4;
    localparam int NOWR_OFS = 8;
    localparam int SVC_OFS  = 8;
    localparam int IRQ_BIT  = 16;
endpackage

// File: rtl/accel_kernel_stub.sv
module accel_kernel_stub #(
    parameter int DW     = 32,
    parameter int SW     = 2,
    parameter int N_IO   = 2,
    parameter int N_OUTS = 2,
    parameter int STEPS  = 4,
    localparam int CW    = $clog2(STEPS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        init,
    input  logic                        run_en,
    input  logic                        cont,
    input  logic                        cb_en,
    input  logic [SW-1:0]               sel,
    input  logic [DW-1:0]               op_a,
    input  logic [DW-1:0]               op_b,
    input  logic [DW-1:0]               op_c,
    input  logic [N_IO-1:0][DW-1:0]     res,
    output logic                        req,
    output logic                        done,
    output logic [SW-1:0]               svc,
    output logic [N_IO-1:0][DW-1:0]     sarg,
    output logic [N_OUTS-1:0][DW-1:0]   outv,
    output logic [CW-1:0]               cnt
);
    typedef struct packed {
        logic [CW-1:0]           cnt;
        logic                    phase;
        logic [N_IO-1:0][DW-1:0] res;
    } k_t;

    k_t q, d;
    logic at_end;

    always_comb begin
        d      = q;
        at_end = (q.cnt == CW'(STEPS));
        if (init) begin
            d.cnt   = '0;
            d.phase = 1'b0;
            d.res   = '0;
        end else if (cont) begin
            d.cnt   = '0;
            d.phase = 1'b1;
            d.res   = res;
        end else if (run_en && !at_end) begin
            d.cnt = q.cnt + 1'b1;
        end
        req  = run_en && at_end && !q.phase && cb_en;
        done = run_en && at_end && (q.phase || !cb_en);
        svc  = sel;
        sarg    = '0;
        sarg[0] = op_a + op_b;
        sarg[1] = op_c;
        outv    = '0;
        outv[0] = q.phase ? (q.res[0] + op_a) : (op_a + op_b);
        outv[1] = q.phase ? q.res[1] : op_c;
        cnt     = q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/accel_seq.sv
module accel_seq
    import accel_pkg::*;
#(
    parameter int SW    = 2,
    parameter int N_SVC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmd,
    input  logic             resume_cmd,
    input  logic             ack_cmd,
    input  logic             k_req,
    input  logic             k_done,
    input  logic [SW-1:0]    k_svc,
    input  logic [N_SVC-1:0] no_read,
    input  logic [N_SVC-1:0] no_write,
    input  logic             flush_ack,
    input  logic             inval_ack,
    output seq_st_e          state,
    output logic             irq,
    output logic [SW-1:0]    svc_id,
    output logic             k_init,
    output logic             k_cont,
    output logic             run_en,
    output logic             cap_svc,
    output logic             cap_out,
    output logic             flush_req,
    output logic             inval_req
);
    typedef struct packed {
        seq_st_e       st;
        logic          irq;
        logic [SW-1:0] svc;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d       = q;
        k_init  = 1'b0;
        k_cont  = 1'b0;
        cap_svc = 1'b0;
        cap_out = 1'b0;
        if (ack_cmd) d.irq = 1'b0;
        case (q.st)
            S_IDLE: if (start_cmd) begin
                d.st   = S_RUN;
                k_init = 1'b1;
            end
            S_RUN: if (k_done) begin
                d.st    = S_DONE;
                d.irq   = 1'b1;
                cap_out = 1'b1;
            end else if (k_req) begin
                cap_svc = 1'b1;
                d.svc   = k_svc;
                if (no_read[k_svc]) begin
                    d.st  = S_PEND;
                    d.irq = 1'b1;
                end else begin
                    d.st = S_FLUSH;
                end
            end
            S_FLUSH: if (flush_ack) begin
                d.st  = S_PEND;
                d.irq = 1'b1;
            end
            S_PEND: if (resume_cmd) begin
                if (no_write[q.svc]) begin
                    d.st   = S_RUN;
                    k_cont = 1'b1;
                end else begin
                    d.st = S_INVAL;
                end
            end
            S_INVAL: if (inval_ack) begin
                d.st   = S_RUN;
                k_cont = 1'b1;
            end
            S_DONE: if (ack_cmd) begin
                d.st   = S_IDLE;
                k_init = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase
        state     = q.st;
        irq       = q.irq;
        svc_id    = q.svc;
        run_en    = (q.st == S_RUN);
        flush_req = (q.st == S_FLUSH);
        inval_req = (q.st == S_INVAL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: S_IDLE, irq: 1'b0, svc: '0};
        else        q <= d;
    end
endmodule

// File: rtl/accel_ctl.sv
module accel_ctl
    import accel_pkg::*;
#(
    parameter int DW     = 32,
    parameter int AW     = 8,
    parameter int N_ARGS = 4,
    parameter int N_IO   = 2,
    parameter int N_OUTS = 2,
    parameter int N_SVC  = 4,
    parameter int STEPS  = 4,
    localparam int SW    = $clog2(N_SVC),
    localparam int CW    = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic [SW-1:0] irq_svc_id,
    output logic          flush_req,
    input  logic          flush_ack,
    output logic          inval_req,
    input  logic          inval_ack
);
    typedef struct packed {
        logic [N_ARGS-1:0][DW-1:0] arg;
        logic [DW-1:0]             cfg;
        logic [N_IO-1:0][DW-1:0]   res;
        logic [N_IO-1:0][DW-1:0]   sarg;
        logic [N_OUTS-1:0][DW-1:0] outv;
    } rf_t;

    rf_t rf_q, rf_d;
    seq_st_e seq_state;
    logic start_cmd, resume_cmd, ack_cmd, ctrl_wr;
    logic k_req, k_done, k_init, k_cont, run_en, cap_svc, cap_out;
    logic [SW-1:0] k_svc;
    logic [N_IO-1:0][DW-1:0] k_sarg;
    logic [N_OUTS-1:0][DW-1:0] k_out;
    logic [CW-1:0] k_cnt;
    logic [1:0] st_code;

    always_comb begin
        ctrl_wr    = reg_wr && (reg_addr == AW'(A_CTRL));
        start_cmd  = ctrl_wr && reg_wdata[C_START];
        resume_cmd = ctrl_wr && reg_wdata[C_RESUME];
        ack_cmd    = ctrl_wr && reg_wdata[C_ACK];
        rf_d = rf_q;
        if (reg_wr) begin
            if (reg_addr == AW'(A_CFG)) rf_d.cfg = reg_wdata;
            for (int i = 0; i < N_ARGS; i++)
                if (reg_addr == AW'(A_ARG + i)) rf_d.arg[i] = reg_wdata;
            for (int i = 0; i < N_IO; i++)
                if (reg_addr == AW'(A_SRES + i)) rf_d.res[i] = reg_wdata;
        end
        if (cap_svc) rf_d.sarg = k_sarg;
        if (cap_out) rf_d.outv = k_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        case (seq_state)
            S_IDLE:  st_code = 2'd0;
            S_PEND:  st_code = 2'd2;
            S_DONE:  st_code = 2'd3;
            default: st_code = 2'd1;
        endcase
        reg_rdata = '0;
        if (reg_addr == AW'(A_STAT)) begin
            reg_rdata[1:0]           = st_code;
            reg_rdata[SVC_OFS +: SW] = irq_svc_id;
            reg_rdata[IRQ_BIT]       = irq;
        end
        if (reg_addr == AW'(A_CFG)) reg_rdata = rf_q.cfg;
        for (int i = 0; i < N_ARGS; i++)
            if (reg_addr == AW'(A_ARG + i)) reg_rdata = rf_q.arg[i];
        for (int i = 0; i < N_OUTS; i++)
            if (reg_addr == AW'(A_OUT + i)) reg_rdata = rf_q.outv[i];
        for (int i = 0; i < N_IO; i++) begin
            if (reg_addr == AW'(A_SARG + i)) reg_rdata = rf_q.sarg[i];
            if (reg_addr == AW'(A_SRES + i)) reg_rdata = rf_q.res[i];
        end
    end

    accel_seq #(.SW(SW), .N_SVC(N_SVC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_cmd(start_cmd), .resume_cmd(resume_cmd), .ack_cmd(ack_cmd),
        .k_req(k_req), .k_done(k_done), .k_svc(k_svc),
        .no_read(rf_q.cfg[N_SVC-1:0]),
        .no_write(rf_q.cfg[NOWR_OFS +: N_SVC]),
        .flush_ack(flush_ack), .inval_ack(inval_ack),
        .state(seq_state), .irq(irq), .svc_id(irq_svc_id),
        .k_init(k_init), .k_cont(k_cont), .run_en(run_en),
        .cap_svc(cap_svc), .cap_out(cap_out),
        .flush_req(flush_req), .inval_req(inval_req)
    );

    accel_kernel_stub #(
        .DW(DW), .SW(SW), .N_IO(N_IO), .N_OUTS(N_OUTS), .STEPS(STEPS)
    ) u_kernel (
        .clk(clk), .rst_n(rst_n),
        .init(k_init), .run_en(run_en), .cont(k_cont),
        .cb_en(rf_q.arg[0][CB_BIT]), .sel(rf_q.arg[0][SW-1:0]),
        .op_a(rf_q.arg[1]), .op_b(rf_q.arg[2]), .op_c(rf_q.arg[3]),
        .res(rf_q.res),
        .req(k_req), .done(k_done), .svc(k_svc),
        .sarg(k_sarg), .outv(k_out), .cnt(k_cnt)
    );
endmodule

// File: rtl/accel_ctl_checker.sv
module accel_ctl_checker
    import accel_pkg::*;
#(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input seq_st_e       state,
    input logic [CW-1:0] kcnt,
    input logic          irq,
    input logic          ack_cmd,
    input logic          start_cmd,
    input logic          resume_cmd,
    input logic          flush_req,
    input logic          flush_ack,
    input logic          inval_req,
    input logic          inval_ack
);
    a_r6_kernel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && $past(state) == S_PEND) |-> $stable(kcnt));

    a_r7_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);

    a_r8_inval_held: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_req && !inval_ack) |=> inval_req);

    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_cmd) |=> irq);

    a_r5_irq_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == S_PEND) |-> irq);

    a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PEND && start_cmd && !resume_cmd) |=> state == S_PEND);

    a_r9_resume_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && resume_cmd && !ack_cmd) |=> state == S_DONE);

    a_r8_single_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_req && inval_req));
endmodule

bind accel_ctl accel_ctl_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(seq_state), .kcnt(k_cnt), .irq(irq),
    .ack_cmd(ack_cmd), .start_cmd(start_cmd), .resume_cmd(resume_cmd),
    .flush_req(flush_req), .flush_ack(flush_ack),
    .inval_req(inval_req), .inval_ack(inval_ack)
);

// File: tb/accel_ctl_bench.sv
module accel_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [1:0]  irq_svc_id;
    logic        flush_req, inval_req;
    logic        flush_ack = 1'b0;
    logic        inval_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int nflush = 0;
    int ninval = 0;
    bit done_run = 0;

    always #10 clk = ~clk;

    accel_ctl u_accel_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .irq_svc_id(irq_svc_id), .flush_req(flush_req), .flush_ack(flush_ack),
        .inval_req(inval_req), .inval_ack(inval_ack)
    );

    localparam int NV = 5;
    localparam logic [31:0] V_CFG [NV] = '{32'h0, 32'h0, 32'h4, 32'h800, 32'h101};
    localparam logic [31:0] V_A0  [NV] = '{32'h00, 32'h11, 32'h12, 32'h13, 32'h10};
    localparam logic [31:0] V_A1  [NV] = '{32'd5, 32'd3, 32'd1, 32'hFFFF_FFFF, 32'd8};
    localparam logic [31:0] V_A2  [NV] = '{32'd7, 32'd4, 32'd2, 32'd1, 32'd8};
    localparam logic [31:0] V_A3  [NV] = '{32'd9, 32'h20, 32'd3, 32'd0, 32'd1};
    localparam logic [31:0] V_R0  [NV] = '{32'd0, 32'd100, 32'd10, 32'd2, 32'd0};
    localparam logic [31:0] V_R1  [NV] = '{32'd0, 32'h55, 32'd20, 32'd3, 32'd0};
    localparam logic [31:0] V_O0  [NV] = '{32'd12, 32'd103, 32'd11, 32'd1, 32'd8};
    localparam logic [31:0] V_O1  [NV] = '{32'd9, 32'h55, 32'd20, 32'd3, 32'd0};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_irq();
        for (int n = 0; n < 500 && !irq; n++) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (flush_req && !flush_ack) begin
                repeat (3) @(negedge clk);
                flush_ack = 1'b1; nflush++;
                @(negedge clk);
                flush_ack = 1'b0;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (inval_req && !inval_ack) begin
                repeat (3) @(negedge clk);
                inval_ack = 1'b1; ninval++;
                @(negedge clk);
                inval_ack = 1'b0;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done_run) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h01, v);
        chk(v[1:0] == 2'd0 && irq == 1'b0, "R1 reset status idle", v, 0);
        wr(8'h13, 32'hA5A5_0001);
        rd(8'h13, v);
        chk(v == 32'hA5A5_0001, "R1 arg readback", v, 32'hA5A5_0001);

        for (int k = 0; k < NV; k++) begin
            bit cb, exp_fl, exp_iv;
            logic [1:0] sid;
            cb = V_A0[k][4];
            sid = V_A0[k][1:0];
            exp_fl = cb && !V_CFG[k][sid];
            exp_iv = cb && !V_CFG[k][8 + sid];
            nflush = 0; ninval = 0;
            wr(8'h02, V_CFG[k]);
            wr(8'h10, V_A0[k]); wr(8'h11, V_A1[k]);
            wr(8'h12, V_A2[k]); wr(8'h13, V_A3[k]);
            wr(8'h00, 32'h1);
            rd(8'h01, v);
            chk(v[1:0] == 2'd1, "R2 running after start", {30'b0, v[1:0]}, 1);
            wait_irq();
            if (cb) begin
                rd(8'h01, v);
                chk(v[1:0] == 2'd2 && v[16], "R5 pending status", v, 32'h10002);
                chk(v[11:8] == {2'b0, sid} && irq_svc_id == sid, "R5 service id",
                    {28'b0, v[11:8]}, {30'b0, sid});
                rd(8'h30, v);
                chk(v == V_A1[k] + V_A2[k], "R5 service arg0", v, V_A1[k] + V_A2[k]);
                rd(8'h31, v);
                chk(v == V_A3[k], "R5 service arg1", v, V_A3[k]);
                chk(nflush == int'(exp_fl), "R7 flush count", nflush, exp_fl);
                wr(8'h38, V_R0[k]); wr(8'h39, V_R1[k]);
                wr(8'h00, 32'h4);
                rd(8'h01, v);
                chk(!irq && v[1:0] == 2'd2, "R10 ack in pending", v, 2);
                wr(8'h00, 32'h2);
                wait_irq();
                chk(ninval == int'(exp_iv), "R8 invalidate count", ninval, exp_iv);
            end else begin
                chk(nflush == 0, "R7 no flush without call", nflush, 0);
            end
            rd(8'h01, v);
            chk(v[1:0] == 2'd3 && irq, "R3 done status", v, 32'h10003);
            rd(8'h20, v);
            chk(v == V_O0[k], "R3 out0", v, V_O0[k]);
            rd(8'h21, v);
            chk(v == V_O1[k], "R3 out1", v, V_O1[k]);
            wr(8'h00, 32'h4);
            rd(8'h01, v);
            chk(v[1:0] == 2'd0 && !irq, "R4 ack returns idle", v, 0);
        end

        wr(8'h00, 32'h2);
        rd(8'h01, v);
        chk(v[1:0] == 2'd0 && !irq, "R9 resume in idle ignored", v, 0);

        wr(8'h02, 32'h101);
        wr(8'h10, 32'h10); wr(8'h11, 32'd1); wr(8'h12, 32'd2); wr(8'h13, 32'd3);
        wr(8'h00, 32'h1);
        wait_irq();
        wr(8'h11, 32'd50);
        wr(8'h00, 32'h1);
        rd(8'h01, v);
        chk(v[1:0] == 2'd2, "R2 start in pending ignored", v, 2);
        rd(8'h30, v);
        chk(v == 32'd3, "R2 service args kept", v, 3);
        repeat (40) @(negedge clk);
        rd(8'h01, v);
        chk(v[1:0] == 2'd2 && irq, "R6 frozen while pending", v, 32'h10002);
        chk(irq, "R10 irq held without ack", irq, 1);
        wr(8'h38, 32'd7); wr(8'h39, 32'd9);
        wr(8'h00, 32'h6);
        wait_irq();
        rd(8'h20, v);
        chk(v == 32'd57, "R3 out0 after call", v, 57);
        wr(8'h00, 32'h2);
        rd(8'h01, v);
        chk(v[1:0] == 2'd3 && irq, "R9 resume in done ignored", v, 32'h10003);
        wr(8'h00, 32'h4);
        rd(8'h01, v);
        chk(v[1:0] == 2'd0, "R4 final idle", v, 0);

        done_run = 1;
        summary();
    end
endmodule